// File: doc/BRIEF.md
# Running-Disparity 8b/10b Line Encoder

This block turns one byte per clock into a ten-bit line character. The character follows the widely used 8b/10b code, which splits each byte into a 5b/6b part and a 3b/4b part. The encoder keeps a running-disparity bit that chooses between the two forms of each sub-block. This keeps the serial stream DC-balanced and gives it enough transitions for the receiver to recover the clock. A control flag selects the special (K) code space. Only the twelve defined K characters are accepted. Any other control request is flagged on an error output and encoded as the data character with the same byte value.

A bypass input switches the block to raw mode. In raw mode a ten-bit character supplied by the caller goes to the output unchanged and the running disparity is frozen. Every input is captured on the rising clock edge, and the result appears on the registered outputs one clock later. There is no handshake: a character is consumed on every clock.

Top module: `enc8b10b_tx`

## Requirements
- R1: While `rst_n` is low, `code_out` is 0, `ctrl_err` is 0 and `rd_pos` is 0, where 0 means negative running disparity.
- R2: Byte bits are read as `din[4:0]` = EDCBA (A in bit 0) and `din[7:5]` = HGF. The output is `code_out[9:4]` = abcdei and `code_out[3:0]` = fghj, with bit a in bit 9 sent first. Data characters use the standard 5b/6b and 3b/4b tables, and each sub-block picks its form from the disparity in force at its start.
- R3: Every encoded character has 4, 5 or 6 ones. `rd_pos` becomes 1 after a character with six ones, becomes 0 after one with four ones, and is unchanged after one with five ones.
- R4: For D.x.7, the alternate 3b/4b code (0111 at negative, 1000 at positive) is used when x is 17, 18 or 20 at negative disparity, or when x is 11, 13 or 14 at positive disparity. Otherwise the primary code (1110 / 0001) is used.
- R5: With `is_ctrl` high, K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded with their K codes, and `ctrl_err` is 0. For example, K28.5 at negative disparity gives 0011111010.
- R6: A control request for any other byte sets `ctrl_err` to 1 for that character. The output is the data encoding of the same byte, and disparity is updated as for data.
- R7: With `bypass` high, `code_out` equals `bypass_char`, `rd_pos` keeps its value and `ctrl_err` is 0, whatever `is_ctrl` and `din` are.
- R8: The outputs change only at the clock edge that captures the input, so the result of an input appears exactly one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Byte to encode, HGF EDCBA |
| is_ctrl | input | 1 | Request a K character |
| bypass | input | 1 | Pass `bypass_char` through unchanged |
| bypass_char | input | 10 | Pre-encoded character for bypass mode |
| code_out | output | 10 | Line character, bit 9 (a) sent first |
| ctrl_err | output | 1 | Control request was not a valid K character |
| rd_pos | output | 1 | Running disparity after the last character, 1 = positive |

## Verification
The assertions check three things on every cycle. Every encoded character carries 4 to 6 ones, and the disparity bit moves in step with that count. Bypass copies the raw character and freezes the disparity. The error flag only follows a control request. Whether each sub-block uses the correct table entry cannot be seen from these properties. That includes the alternate D.x.7 choice, the K code forms and the bit order, so the bench's known-good vector stream is the only thing that shows them. The same applies to disparity carried across mixed data, control and bypass characters, and to its return to negative after a reset in mid-stream.

// File: rtl/enc8b10b_tx.sv
module enc8b10b_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       is_ctrl,
  input  logic       bypass,
  input  logic [9:0] bypass_char,
  output logic [9:0] code_out,
  output logic       ctrl_err,
  output logic       rd_pos
);

  logic [4:0] x;
  logic [2:0] y;
  assign x = din[4:0];
  assign y = din[7:5];

  logic k_ok, k28;
  assign k_ok = is_ctrl && (x == 5'd28 ||
                (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
  assign k28 = k_ok && x == 5'd28;

  logic [5:0] six_n;
  always_comb begin
    case (x)
      5'd0:  six_n = 6'b100111;
      5'd1:  six_n = 6'b011101;
      5'd2:  six_n = 6'b101101;
      5'd3:  six_n = 6'b110001;
      5'd4:  six_n = 6'b110101;
      5'd5:  six_n = 6'b101001;
      5'd6:  six_n = 6'b011001;
      5'd7:  six_n = 6'b111000;
      5'd8:  six_n = 6'b111001;
      5'd9:  six_n = 6'b100101;
      5'd10: six_n = 6'b010101;
      5'd11: six_n = 6'b110100;
      5'd12: six_n = 6'b001101;
      5'd13: six_n = 6'b101100;
      5'd14: six_n = 6'b011100;
      5'd15: six_n = 6'b010111;
      5'd16: six_n = 6'b011011;
      5'd17: six_n = 6'b100011;
      5'd18: six_n = 6'b010011;
      5'd19: six_n = 6'b110010;
      5'd20: six_n = 6'b001011;
      5'd21: six_n = 6'b101010;
      5'd22: six_n = 6'b011010;
      5'd23: six_n = 6'b111010;
      5'd24: six_n = 6'b110011;
      5'd25: six_n = 6'b100110;
      5'd26: six_n = 6'b010110;
      5'd27: six_n = 6'b110110;
      5'd28: six_n = 6'b001110;
      5'd29: six_n = 6'b101110;
      5'd30: six_n = 6'b011110;
      default: six_n = 6'b101011;
    endcase
    if (k28) six_n = 6'b001111;
  end

  logic bal6, flip6, rd6;
  logic [5:0] six;
  assign bal6  = ($countones(six_n) == 3);
  assign flip6 = !bal6 || (x == 5'd7 && !k28);
  assign six   = (rd_pos && flip6) ? ~six_n : six_n;
  assign rd6   = rd_pos ^ !bal6;

  logic alt7;
  assign alt7 = (y == 3'd7) &&
                ((!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                 ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));

  logic [3:0] four_n;
  always_comb begin
    if (k_ok) begin
      case (y)
        3'd0: four_n = 4'b1011;
        3'd1: four_n = 4'b0110;
        3'd2: four_n = 4'b1010;
        3'd3: four_n = 4'b1100;
        3'd4: four_n = 4'b1101;
        3'd5: four_n = 4'b0101;
        3'd6: four_n = 4'b1001;
        default: four_n = 4'b0111;
      endcase
    end else begin
      case (y)
        3'd0: four_n = 4'b1011;
        3'd1: four_n = 4'b1001;
        3'd2: four_n = 4'b0101;
        3'd3: four_n = 4'b1100;
        3'd4: four_n = 4'b1101;
        3'd5: four_n = 4'b1010;
        3'd6: four_n = 4'b0110;
        default: four_n = alt7 ? 4'b0111 : 4'b1110;
      endcase
    end
  end

  logic bal4, flip4, rd_next;
  logic [3:0] four;
  assign bal4    = ($countones(four_n) == 2);
  assign flip4   = k_ok || !bal4 || y == 3'd3;
  assign four    = (rd6 && flip4) ? ~four_n : four_n;
  assign rd_next = rd6 ^ !bal4;

  logic enc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out <= '0;
      ctrl_err <= 1'b0;
      rd_pos   <= 1'b0;
      enc_q    <= 1'b0;
    end else if (bypass) begin
      code_out <= bypass_char;
      ctrl_err <= 1'b0;
      enc_q    <= 1'b0;
    end else begin
      code_out <= {six, four};
      ctrl_err <= is_ctrl && !k_ok;
      rd_pos   <= rd_next;
      enc_q    <= 1'b1;
    end
  end

  assert_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_q |-> ($countones(code_out) >= 4 && $countones(code_out) <= 6));

  assert_rd_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_q |-> (($countones(code_out) == 5 && rd_pos == $past(rd_pos)) ||
               ($countones(code_out) == 6 && rd_pos) ||
               ($countones(code_out) == 4 && !rd_pos)));

  assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (code_out == $past(bypass_char) && rd_pos == $past(rd_pos) && !ctrl_err));

  assert_err_needs_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_err |-> $past(is_ctrl && !bypass));

  assert_run_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_q |-> (code_out[9:4] != 6'b111111 && code_out[9:4] != 6'b000000));

endmodule

// File: tb/test_enc8b10b_tx.sv
module test_enc8b10b_tx;
  localparam time PERIOD = 10ns;
  localparam int NV = 18;

  // {bypass, is_ctrl, din, bypass_char, expected code, expected rd, expected err}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 10'h000, 10'b1001110100, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hBC, 10'h000, 10'b0011111010, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'hB5, 10'h000, 10'b1010101010, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'hEB, 10'h000, 10'b1101001000, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'hF1, 10'h000, 10'b1000110111, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h67, 10'h000, 10'b0001110011, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h1C, 10'h000, 10'b1100001011, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'hFF, 10'h000, 10'b0101001110, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 10'h3E0, 10'b1111100000, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'hF7, 10'h000, 10'b0001010111, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h23, 10'h000, 10'b1100011001, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h01, 10'h000, 10'b1000101011, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hEE, 10'h000, 10'b0111001000, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'hF4, 10'h000, 10'b0010110111, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'hD8, 10'h000, 10'b0011000110, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hFC, 10'h000, 10'b0011111000, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h01, 10'h155, 10'b0101010101, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h97, 10'h000, 10'b1110100010, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] din = '0;
  logic is_ctrl = 1'b0, bypass = 1'b0;
  logic [9:0] bypass_char = '0;
  logic [9:0] code_out;
  logic ctrl_err, rd_pos;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  enc8b10b_tx i_enc8b10b_tx (
    .clk(clk), .rst_n(rst_n), .din(din), .is_ctrl(is_ctrl), .bypass(bypass),
    .bypass_char(bypass_char), .code_out(code_out), .ctrl_err(ctrl_err), .rd_pos(rd_pos)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] prev;
    repeat (3) @(negedge clk);
    check("R1 code", code_out, 10'd0);
    check("R1 err", {9'd0, ctrl_err}, 10'd0);
    check("R1 rd", {9'd0, rd_pos}, 10'd0);
    rst_n = 1'b1;
    prev = code_out;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      bypass = v[31];
      is_ctrl = v[30];
      din = v[29:22];
      bypass_char = v[21:12];
      #1;
      check("R8 hold", code_out, prev);
      @(negedge clk);
      if (v[31]) tag = "R7";
      else if (v[0]) tag = "R6";
      else if (v[30]) tag = "R5";
      else if (v[29:22] == 8'hEB || v[29:22] == 8'hF1 || v[29:22] == 8'hEE || v[29:22] == 8'hF4) tag = "R4";
      else tag = "R2";
      check({tag, " code"}, code_out, v[11:2]);
      check("R3 rd", {9'd0, rd_pos}, {9'd0, v[1]});
      check({tag, " err"}, {9'd0, ctrl_err}, {9'd0, v[0]});
      prev = code_out;
    end
    // R1: reset in mid-stream returns disparity to negative
    bypass = 1'b0; is_ctrl = 1'b1; din = 8'hBC;
    @(negedge clk);
    check("R3 rd before reset", {9'd0, rd_pos}, 10'd1);
    rst_n = 1'b0;
    #1;
    check("R1 async code", code_out, 10'd0);
    check("R1 async rd", {9'd0, rd_pos}, 10'd0);
    @(negedge clk);
    rst_n = 1'b1;
    is_ctrl = 1'b0; din = 8'h00;
    @(negedge clk);
    check("R1 restart D.0.0", code_out, 10'b1001110100);
    // R7: bypass with positive disparity keeps it positive
    is_ctrl = 1'b1; din = 8'hBC;
    @(negedge clk);
    bypass = 1'b1; bypass_char = 10'h2AA; din = 8'h01;
    @(negedge clk);
    check("R7 code", code_out, 10'h2AA);
    check("R7 rd", {9'd0, rd_pos}, 10'd1);
    check("R7 err", {9'd0, ctrl_err}, 10'd0);
    bypass = 1'b0; is_ctrl = 1'b1; din = 8'h1C;
    @(negedge clk);
    check("R5 K28.0 after bypass", code_out, 10'b1100001011);
    finish_run();
  end
endmodule